// File: doc/BRIEF.md
# Banked Inter-Core Interrupt and Mailbox Unit

This unit lets the cores of a multi-core cluster signal one another. Every core owns a private register bank: an interrupt status word, an enable word, write-only set and clear words, and eight 32-bit mailbox words. All cores reach their bank through one shared 32-bit register port. The identity of the requesting core travels with each access, and that identity picks the bank. The port also decodes a vector-send command. This command raises one interrupt bit in the status word of another core.

A second, 64-bit command port forwards a write into the bank of another core. The write goes either to one of that core's mailbox words or to any register address in its bank. Each byte of the forwarded word can be kept or replaced. When any byte is to be kept, the unit first reads the destination word and then writes the merged result. Only one forwarded command is in flight at a time, and the port drops its ready signal while the command is being handled. A target number with no core behind it returns an error in the same cycle and changes no state. Each core gets one interrupt line.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset, every status, enable and mailbox word of every bank reads zero, every interrupt line is low, and `sp_ready` is high.
- R2: A register-port access with `rp_id` below the core count touches only that core's bank. Word addresses are decoded from `rp_addr[7:2]`: 0x00 status (read only), 0x04 enable (read/write), 0x08 set (write only), 0x0C clear (write only), 0x20 to 0x3C mailbox words 0 to 7, 0x40 vector send. Write-only words read as zero.
- R3: Writing the set word ORs the data into status. Writing the clear word clears the status bits written as 1. When a bit is both set and cleared in the same cycle, it ends up set.
- R4: `irq[c]` is high exactly when status and enable of core c share a 1 bit.
- R5: A register-port write to 0x40 takes the target core from data bits 25:16 and the vector from bits 4:0. One clock later, exactly that one bit is set in the target's status word, for vectors 0 through 31.
- R6: A target at or above the core count, on either port, raises `rp_err` or `sp_err` in the cycle of the access. No register changes, and `sp_ready` stays high.
- R7: A mailbox command (`sp_general` = 0) writes data bits 63:32 into the target's mailbox word selected by command bits 4:2.
- R8: Command bits 30:27 are byte keeps, with bit 27 belonging to byte 0. A 1 keeps the destination's old byte. A 0 takes the new byte.
- R9: A general command (`sp_general` = 1) uses command bits 7:0 as the register address in the target's bank; bits 15:8 are ignored. It writes with the same merge, so a write to the set word raises the target's interrupt.
- R10: After an accepted good command, `sp_ready` is low for 1 cycle when all keep bits are 0, and for 2 cycles otherwise. The write is visible when `sp_ready` returns high.
- R11: A forwarded set and a register-port clear that land on the same core in the same cycle are both applied, and the set wins on shared bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rp_valid | input | 1 | Register-port access strobe |
| rp_write | input | 1 | 1 = write, 0 = read |
| rp_id | input | ID_W | Requesting core, selects the bank |
| rp_addr | input | 8 | Register address (low 8 bits) |
| rp_wdata | input | 32 | Write data |
| rp_rdata | output | 32 | Read data, combinational |
| rp_err | output | 1 | Vector send to a missing core |
| sp_valid | input | 1 | Forward-command strobe |
| sp_general | input | 1 | 0 = mailbox command, 1 = general command |
| sp_cmd | input | 64 | Forward command word |
| sp_ready | output | 1 | Command port can accept |
| sp_err | output | 1 | Forward command to a missing core |
| irq | output | NCORE | One interrupt line per core |

## Verification
The forwarded write from the command port and a register-port write can fall in the same clock edge, and both may target the status word of the same core. The bench provokes this by accepting a general command aimed at core 2's set word. In the next cycle, the cycle in which the forwarded write lands, it drives a register-port clear to core 2 covering the same bit and one other bit. The result is judged by reading core 2's status afterwards. The shared bit must remain set, and the other bit must be gone.

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int NCORE = 4,
  parameter int ID_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rp_valid,
  input  logic             rp_write,
  input  logic [ID_W-1:0]  rp_id,
  input  logic [7:0]       rp_addr,
  input  logic [31:0]      rp_wdata,
  output logic [31:0]      rp_rdata,
  output logic             rp_err,
  input  logic             sp_valid,
  input  logic             sp_general,
  input  logic [63:0]      sp_cmd,
  output logic             sp_ready,
  output logic             sp_err,
  output logic [NCORE-1:0] irq
);
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam int NBUF = 8;
  localparam logic [ID_W-1:0] NC = ID_W'(NCORE);
  localparam logic [5:0] A_STAT = 6'h00, A_EN = 6'h01, A_SET = 6'h02, A_CLR = 6'h03, A_SEND = 6'h10;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} fsm_t;
  fsm_t state;

  logic [31:0] st [NCORE];
  logic [31:0] en [NCORE];
  logic [31:0] mb [NCORE][NBUF];

  logic [CW-1:0] f_core;
  logic [7:0]    f_addr;
  logic [31:0]   f_data, f_old, wr_word;
  logic [3:0]    f_mask;

  function automatic logic [31:0] rd_reg(input logic [CW-1:0] c, input logic [7:0] a);
    rd_reg = '0;
    if (a[7:2] == A_STAT)      rd_reg = st[c];
    else if (a[7:2] == A_EN)   rd_reg = en[c];
    else if (a[7:5] == 3'b001) rd_reg = mb[c][a[4:2]];
  endfunction

  wire              rp_ok   = rp_id < NC;
  wire [CW-1:0]     rp_core = rp_id[CW-1:0];
  wire              rp_wr   = rp_valid && rp_write && rp_ok;
  wire              ipi_go  = rp_valid && rp_write && rp_addr[7:2] == A_SEND;
  wire [ID_W-1:0]   ipi_tgt = rp_wdata[16 +: ID_W];
  wire              ipi_bad = ipi_tgt >= NC;
  wire [ID_W-1:0]   sp_tgt  = sp_cmd[16 +: ID_W];
  wire              sp_bad  = sp_tgt >= NC;
  wire              sp_acc  = sp_valid && sp_ready;
  wire              fw_we   = state == S_WR;

  assign sp_ready = state == S_IDLE;
  assign sp_err   = sp_acc && sp_bad;
  assign rp_err   = ipi_go && ipi_bad;
  assign rp_rdata = (rp_valid && !rp_write && rp_ok) ? rd_reg(rp_core, rp_addr) : '0;

  for (genvar i = 0; i < 4; i++) begin : g_merge
    assign wr_word[8*i +: 8] = f_mask[i] ? f_old[8*i +: 8] : f_data[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      f_core <= '0;
      f_addr <= '0;
      f_data <= '0;
      f_mask <= '0;
      f_old  <= '0;
    end else begin
      case (state)
        S_IDLE: if (sp_acc && !sp_bad) begin
          f_core <= sp_tgt[CW-1:0];
          f_addr <= sp_general ? sp_cmd[7:0] : {3'b001, sp_cmd[4:2], 2'b00};
          f_data <= sp_cmd[63:32];
          f_mask <= sp_cmd[30:27];
          f_old  <= '0;
          state  <= (sp_cmd[30:27] != 4'd0) ? S_RD : S_WR;
        end
        S_RD: begin
          f_old <= rd_reg(f_core, f_addr);
          state <= S_WR;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [31:0] set_v [NCORE];
  logic [31:0] clr_v [NCORE];

  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      set_v[c] = '0;
      clr_v[c] = '0;
      if (rp_wr && rp_core == CW'(c) && rp_addr[7:2] == A_SET) set_v[c] |= rp_wdata;
      if (rp_wr && rp_core == CW'(c) && rp_addr[7:2] == A_CLR) clr_v[c] |= rp_wdata;
      if (fw_we && f_core == CW'(c) && f_addr[7:2] == A_SET)   set_v[c] |= wr_word;
      if (fw_we && f_core == CW'(c) && f_addr[7:2] == A_CLR)   clr_v[c] |= wr_word;
      if (ipi_go && !ipi_bad && ipi_tgt[CW-1:0] == CW'(c))     set_v[c] |= 32'd1 << rp_wdata[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCORE; c++) begin
        st[c] <= '0;
        en[c] <= '0;
        for (int b = 0; b < NBUF; b++) mb[c][b] <= '0;
      end
    end else begin
      for (int c = 0; c < NCORE; c++) begin
        st[c] <= (st[c] & ~clr_v[c]) | set_v[c];
        if (fw_we && f_core == CW'(c) && f_addr[7:2] == A_EN)
          en[c] <= wr_word;
        else if (rp_wr && rp_core == CW'(c) && rp_addr[7:2] == A_EN)
          en[c] <= rp_wdata;
        for (int b = 0; b < NBUF; b++) begin
          if (fw_we && f_core == CW'(c) && f_addr[7:5] == 3'b001 && f_addr[4:2] == 3'(b))
            mb[c][b] <= wr_word;
          else if (rp_wr && rp_core == CW'(c) && rp_addr[7:5] == 3'b001 && rp_addr[4:2] == 3'(b))
            mb[c][b] <= rp_wdata;
        end
      end
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assign irq[c] = |(st[c] & en[c]);

    p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_valid && rp_write && rp_id == ID_W'(c) && rp_addr[7:2] == A_SET)
      |=> ((st[c] & $past(rp_wdata)) == $past(rp_wdata)));

    p_vec_send_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_valid && rp_write && rp_addr[7:2] == A_SEND && rp_wdata[16 +: ID_W] == ID_W'(c))
      |=> st[c][$past(rp_wdata[4:0])]);
  end

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_valid && sp_ready && !sp_err) |=> !sp_ready);

  p_busy_max_two_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_ready && $past(!sp_ready)) |=> sp_ready);

  p_err_stays_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_err |=> sp_ready);

  p_err_only_on_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_err |-> (sp_valid && sp_ready));
endmodule

// File: tb/ipi_mailbox_tb.sv
module ipi_mailbox_tb;
  localparam int NCORE = 4;
  localparam int ID_W = 10;

  logic clk = 0, rst_n = 0;
  logic rp_valid = 0, rp_write = 0;
  logic [ID_W-1:0] rp_id = '0;
  logic [7:0] rp_addr = '0;
  logic [31:0] rp_wdata = '0, rp_rdata;
  logic rp_err;
  logic sp_valid = 0, sp_general = 0;
  logic [63:0] sp_cmd = '0;
  logic sp_ready, sp_err;
  logic [NCORE-1:0] irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipi_mailbox #(.NCORE(NCORE), .ID_W(ID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rp_valid(rp_valid), .rp_write(rp_write), .rp_id(rp_id),
    .rp_addr(rp_addr), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .rp_err(rp_err),
    .sp_valid(sp_valid), .sp_general(sp_general), .sp_cmd(sp_cmd), .sp_ready(sp_ready),
    .sp_err(sp_err), .irq(irq));

  // {read, core[1:0], addr[7:0], data[31:0]}: read entries compare data
  localparam logic [42:0] TBL [12] = '{
    {1'b0, 2'd0, 8'h04, 32'h0000_00F0},
    {1'b0, 2'd1, 8'h20, 32'hDEAD_BEEF},
    {1'b0, 2'd0, 8'h20, 32'h1111_2222},
    {1'b1, 2'd1, 8'h20, 32'hDEAD_BEEF},
    {1'b1, 2'd0, 8'h20, 32'h1111_2222},
    {1'b1, 2'd0, 8'h04, 32'h0000_00F0},
    {1'b1, 2'd2, 8'h20, 32'h0000_0000},
    {1'b0, 2'd0, 8'h08, 32'h0000_0011},
    {1'b1, 2'd0, 8'h00, 32'h0000_0011},
    {1'b1, 2'd0, 8'h08, 32'h0000_0000},
    {1'b0, 2'd0, 8'h0C, 32'h0000_0001},
    {1'b1, 2'd0, 8'h00, 32'h0000_0010}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rp_wr(input int id, input logic [7:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    rp_valid = 1; rp_write = 1; rp_id = ID_W'(id); rp_addr = a; rp_wdata = d;
    #1 err = rp_err;
    @(posedge clk);
    #1 rp_valid = 0; rp_write = 0;
  endtask

  task automatic rp_rd(input int id, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rp_valid = 1; rp_write = 0; rp_id = ID_W'(id); rp_addr = a;
    #1 d = rp_rdata;
    rp_valid = 0;
  endtask

  function automatic logic [63:0] mk(input logic [31:0] d, input logic [3:0] m, input int t, input logic [15:0] lo);
    return {d, 1'b0, m, 1'b0, 10'(t), lo};
  endfunction

  task automatic send(input logic gen, input logic [63:0] cmd, output int busy, output logic err);
    @(negedge clk);
    sp_valid = 1; sp_general = gen; sp_cmd = cmd;
    #1 err = sp_err;
    @(posedge clk);
    @(negedge clk);
    sp_valid = 0;
    busy = 0;
    while (!sp_ready && busy < 10) begin
      busy++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    int busy;

    repeat (3) @(posedge clk);
    #1;
    chk(irq == '0, "R1 irq", 64'(irq), 0);
    chk(sp_ready, "R1 ready", 64'(sp_ready), 1);
    @(negedge clk) rst_n = 1;
    for (int c = 0; c < NCORE; c++) begin
      rp_rd(c, 8'h00, d); chk(d == 0, "R1 status", d, 0);
      rp_rd(c, 8'h3C, d); chk(d == 0, "R1 mailbox", d, 0);
    end

    // R2 R3: table walk
    for (int i = 0; i < 12; i++) begin
      if (TBL[i][42]) begin
        rp_rd(int'(TBL[i][41:40]), TBL[i][39:32], d);
        chk(d == TBL[i][31:0], "R2/R3 table", d, TBL[i][31:0]);
      end else begin
        rp_wr(int'(TBL[i][41:40]), TBL[i][39:32], TBL[i][31:0], e);
      end
    end

    // R4
    #1 chk(irq == 4'b0001, "R4 irq on", 64'(irq), 1);
    rp_wr(0, 8'h04, 32'h0, e);
    #1 chk(irq == 4'b0000, "R4 irq off", 64'(irq), 0);

    // R5
    rp_wr(0, 8'h40, (32'd2 << 16) | 32'd5, e);
    chk(e == 0, "R5 no err", 64'(e), 0);
    rp_rd(2, 8'h00, d); chk(d == 32'h20, "R5 target", d, 32'h20);
    rp_rd(3, 8'h00, d); chk(d == 32'h0, "R5 other", d, 0);

    // R6 register port
    rp_wr(1, 8'h40, (32'd4 << 16) | 32'd3, e);
    chk(e == 1, "R6 rp_err", 64'(e), 1);
    rp_rd(0, 8'h00, d); chk(d == 32'h10, "R6 core0", d, 32'h10);
    rp_rd(1, 8'h00, d); chk(d == 32'h0, "R6 core1", d, 0);
    rp_rd(2, 8'h00, d); chk(d == 32'h20, "R6 core2", d, 32'h20);
    rp_rd(3, 8'h00, d); chk(d == 32'h0, "R6 core3", d, 0);

    // R7 R10
    send(0, mk(32'hCAFE_F00D, 4'b0000, 1, 16'h000C), busy, e);
    chk(busy == 1, "R10 busy nomask", busy, 1);
    rp_rd(1, 8'h2C, d); chk(d == 32'hCAFE_F00D, "R7 mailbox", d, 32'hCAFE_F00D);
    rp_rd(1, 8'h20, d); chk(d == 32'hDEAD_BEEF, "R7 neighbour", d, 32'hDEAD_BEEF);

    // R8 R10
    send(0, mk(32'h1234_5678, 4'b0101, 1, 16'h000C), busy, e);
    chk(busy == 2, "R10 busy mask", busy, 2);
    rp_rd(1, 8'h2C, d); chk(d == 32'h12FE_560D, "R8 merge", d, 32'h12FE_560D);

    // R9
    send(1, mk(32'h0000_0100, 4'b0000, 3, 16'h1108), busy, e);
    rp_rd(3, 8'h00, d); chk(d == 32'h100, "R9 set via general", d, 32'h100);
    rp_wr(3, 8'h04, 32'h0000_0100, e);
    send(1, mk(32'hAABB_CCDD, 4'b1110, 3, 16'h0004), busy, e);
    rp_rd(3, 8'h04, d); chk(d == 32'h0000_01DD, "R9 R8 enable merge", d, 32'h1DD);
    #1 chk(irq == 4'b1000, "R9 irq", 64'(irq), 64'h8);

    // R5 boundary vector 31
    rp_wr(0, 8'h40, (32'd3 << 16) | 32'd31, e);
    rp_rd(3, 8'h00, d); chk(d == 32'h8000_0100, "R5 vector31", d, 32'h8000_0100);

    // R6 command port
    send(0, mk(32'hFFFF_FFFF, 4'b0000, 7, 16'h000C), busy, e);
    chk(e == 1, "R6 sp_err", 64'(e), 1);
    chk(busy == 0, "R6 ready kept", busy, 0);
    rp_rd(1, 8'h2C, d); chk(d == 32'h12FE_560D, "R6 no write", d, 32'h12FE_560D);

    // R11: forwarded set and register clear in the same cycle
    @(negedge clk);
    sp_valid = 1; sp_general = 1; sp_cmd = mk(32'h0000_0200, 4'b0000, 2, 16'h0008);
    @(posedge clk);
    @(negedge clk);
    sp_valid = 0;
    rp_valid = 1; rp_write = 1; rp_id = ID_W'(2); rp_addr = 8'h0C; rp_wdata = 32'h0000_0220;
    @(posedge clk);
    #1 rp_valid = 0; rp_write = 0;
    rp_rd(2, 8'h00, d); chk(d == 32'h200, "R11 set wins", d, 32'h200);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule